// File: doc/BRIEF.md
# Dual-Bank IN Endpoint Buffer Manager

This block holds the packet data of a device-to-host endpoint in one or two banks. A CPU-side port fills the bank that is currently free, one byte per cycle, and hands it over with a commit pulse. The committed banks form a small queue. A host-side port reads bytes from the oldest committed bank and releases it with a done pulse. With two banks, the CPU can fill one bank while the host drains the other. The ready flag comes back in the cycle after a commit whenever the other bank is still free.

The CPU can withdraw the bank it committed most recently with a kill request, so that the bank is never sent. The request shows up as a self-clearing pending bit for one cycle. During that cycle the CPU side is blocked. The kill then either removes the last committed bank or does nothing if no bank is busy. An abort routine repeats the kill until the busy count reaches zero. An IN token that arrives while no bank is busy raises a sticky underflow flag and gives a one-cycle NAK pulse. Setting `NUM_BANKS` to 1 turns the block into a single-bank endpoint.

Top module: `inep_buf_mgr`

## Requirements
- R1: Reset state: busy count 0, `tx_ready_o`=1, `wr_allowed_o`=1, CPU byte count 0, `kill_busy_o`=0, `underflow_o`=0, `host_nak_o`=0, `host_len_o`=0.
- R2: A `cpu_wr_i` pulse while `wr_allowed_o`=1 stores `cpu_data_i` at the next byte position of the CPU bank and raises `cpu_cnt_o` by one. `wr_allowed_o` drops once the count reaches `DEPTH`. Writes while `wr_allowed_o`=0 leave the count unchanged.
- R3: A `cpu_commit_i` pulse while `tx_ready_o`=1 adds one to the busy count, records the byte count as that bank's length and clears `cpu_cnt_o`. `tx_ready_o` is 1 in the next cycle exactly when busy < `NUM_BANKS`. A commit while `tx_ready_o`=0 is ignored.
- R4: `host_data_o` shows the bytes of the oldest committed bank in the order they were written, and each `host_rd_i` advances by one byte. `host_len_o` gives that bank's length.
- R5: A `host_done_i` pulse while the busy count is non-zero releases the oldest bank. The busy count drops by one and `tx_ready_o` comes back.
- R6: With two banks, the CPU writes into the free bank in the same cycles that the host reads the committed one, and neither disturbs the other.
- R7: A `cpu_kill_i` pulse sets `kill_busy_o` for exactly one cycle. When that cycle ends, if the busy count is non-zero, the most recently committed bank is removed: busy drops by one, the older bank stays intact, `cpu_cnt_o` clears and the removed data is never presented to the host. With busy 0 the kill changes nothing.
- R8: While `kill_busy_o`=1, `tx_ready_o` and `wr_allowed_o` are 0, and CPU writes and commits are ignored.
- R9: `host_in_i` while the busy count is 0 sets `underflow_o` (it stays set until `underflow_clr_i`) and pulses `host_nak_o` for one cycle. The busy count is unchanged. While busy is 0, `host_len_o` is 0. `host_in_i` with a busy bank gives no NAK.
- R10: With `NUM_BANKS`=1, `tx_ready_o` stays 0 after a commit until the host releases the bank.
- R11: The busy count never exceeds `NUM_BANKS`.
- R12: If `host_done_i` arrives in the same cycle that a pending kill executes with two busy banks, both banks are freed and the busy count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU byte write strobe |
| cpu_data_i | input | DATA_W | CPU write byte |
| cpu_commit_i | input | 1 | Hand the current bank to the host |
| cpu_kill_i | input | 1 | Request to kill the last committed bank |
| underflow_clr_i | input | 1 | Clears the underflow flag |
| host_in_i | input | 1 | IN token seen by the host side |
| host_rd_i | input | 1 | Host consumes one byte |
| host_done_i | input | 1 | Host finished the oldest bank |
| tx_ready_o | output | 1 | A bank is free for the CPU |
| wr_allowed_o | output | 1 | CPU may write a byte now |
| kill_busy_o | output | 1 | Kill request pending |
| cpu_cnt_o | output | CNT_W | Bytes in the CPU bank |
| busy_cnt_o | output | BUSY_W | Committed banks |
| host_avail_o | output | 1 | At least one bank committed |
| host_data_o | output | DATA_W | Current host byte |
| host_len_o | output | CNT_W | Length of the oldest bank, 0 when none |
| host_nak_o | output | 1 | NAK pulse on underflow |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The bound checker checks these on every cycle: the busy-count bound, the one-cycle life of the kill bit, the CPU being blocked while a kill is pending, the count rising by one on an accepted commit and falling by one on a release, the underflow/NAK response to an IN token on an empty endpoint, and the zero length shown when idle. The bench scenarios cover what needs data and history. The byte order in each bank is checked over all nine length splits of one bank pair, with CPU writes running alongside host reads. The scenarios also show that a killed bank never reaches the host, that the older bank survives a kill, that a kill coinciding with a release empties both banks, and how the one-bank variant holds back the ready flag.

// File: rtl/inep_pkg.sv
package inep_pkg;
  function automatic int ring_inc(int idx, int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  function automatic int ring_sum(int a, int b, int n);
    int s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction
endpackage

// File: rtl/inep_bank_ctrl.sv
module inep_bank_ctrl #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BUSY_W    = 2,
  parameter int unsigned BANK_W    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              kill_i,
  input  logic              done_i,
  output logic              tx_ready_o,
  output logic              commit_fire_o,
  output logic              done_fire_o,
  output logic              kill_fire_o,
  output logic              kill_pend_o,
  output logic              head_lost_o,
  output logic [BANK_W-1:0] head_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [BUSY_W-1:0] busy_o
);
  import inep_pkg::*;

  logic [BUSY_W-1:0] busy_q, busy_mid, busy_d;
  logic [BANK_W-1:0] head_q, head_d;
  logic              kill_q, kill_d;

  always_comb begin
    tx_ready_o    = (int'(busy_q) < int'(NUM_BANKS)) && !kill_q;
    commit_fire_o = commit_i && tx_ready_o;
    done_fire_o   = done_i && (busy_q != '0);
    // release first, then the kill sees what is left
    busy_mid      = busy_q - BUSY_W'(done_fire_o);
    kill_fire_o   = kill_q && (busy_mid != '0);
    busy_d        = busy_mid - BUSY_W'(kill_fire_o) + BUSY_W'(commit_fire_o);
    head_lost_o   = done_fire_o || (kill_fire_o && (busy_mid == BUSY_W'(1)));
    head_d        = done_fire_o ? BANK_W'(ring_inc(int'(head_q), int'(NUM_BANKS))) : head_q;
    kill_d        = kill_q ? 1'b0 : kill_i;
    wr_bank_o     = BANK_W'(ring_sum(int'(head_q), int'(busy_q), int'(NUM_BANKS)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      head_q <= '0;
      kill_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      head_q <= head_d;
      kill_q <= kill_d;
    end
  end

  assign head_o      = head_q;
  assign busy_o      = busy_q;
  assign kill_pend_o = kill_q;
endmodule

// File: rtl/inep_cpu_port.sv
module inep_cpu_port #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             tx_ready_i,
  input  logic             commit_fire_i,
  input  logic             kill_fire_i,
  output logic             wr_allowed_o,
  output logic             wr_fire_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_allowed_o = tx_ready_i && (int'(cnt_q) < int'(DEPTH));
    wr_fire_o    = wr_i && wr_allowed_o;
    cnt_d        = cnt_q;
    if (commit_fire_i || kill_fire_i) cnt_d = '0;
    else if (wr_fire_o)               cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wr_addr_o = cnt_q[PTR_W-1:0];
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/inep_bank_store.sv
module inep_bank_store #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned PTR_W     = 3,
  parameter int unsigned BANK_W    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_fire_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_fire_i,
  input  logic [CNT_W-1:0]  commit_len_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  rd_len_o
);
  if (NUM_BANKS == 1) begin : g_one
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0]  len_q;
    logic              unused_bank;

    assign unused_bank = ^{wr_bank_i, rd_bank_i};

    always_ff @(posedge clk_i) begin
      if (wr_fire_i) mem_q[wr_addr_i] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            len_q <= '0;
      else if (commit_fire_i) len_q <= commit_len_i;
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign rd_len_o  = len_q;
  end else begin : g_multi
    logic [DATA_W-1:0] mem_q [NUM_BANKS][DEPTH];
    logic [CNT_W-1:0]  len_q [NUM_BANKS];

    always_ff @(posedge clk_i) begin
      if (wr_fire_i) mem_q[wr_bank_i][wr_addr_i] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int b = 0; b < int'(NUM_BANKS); b++) len_q[b] <= '0;
      end else if (commit_fire_i) begin
        len_q[wr_bank_i] <= commit_len_i;
      end
    end

    assign rd_data_o = mem_q[rd_bank_i][rd_addr_i];
    assign rd_len_o  = len_q[rd_bank_i];
  end
endmodule

// File: rtl/inep_host_port.sv
module inep_host_port #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned BUSY_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_in_i,
  input  logic              host_rd_i,
  input  logic              uf_clr_i,
  input  logic [BUSY_W-1:0] busy_i,
  input  logic [CNT_W-1:0]  head_len_i,
  input  logic              head_lost_i,
  output logic [PTR_W-1:0]  rd_addr_o,
  output logic              nak_o,
  output logic              underflow_o
);
  logic [CNT_W-1:0] rd_q;
  logic             rd_fire, empty_in;
  logic             nak_q, uf_q;

  assign rd_fire  = host_rd_i && (busy_i != '0) && (rd_q < head_len_i);
  assign empty_in = host_in_i && (busy_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      nak_q <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      if (head_lost_i)  rd_q <= '0;
      else if (rd_fire) rd_q <= rd_q + CNT_W'(1);
      nak_q <= empty_in;
      if (empty_in)      uf_q <= 1'b1;
      else if (uf_clr_i) uf_q <= 1'b0;
    end
  end

  assign rd_addr_o   = rd_q[PTR_W-1:0];
  assign nak_o       = nak_q;
  assign underflow_o = uf_q;
endmodule

// File: rtl/inep_buf_mgr.sv
module inep_buf_mgr #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1),
  localparam int unsigned BUSY_W   = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cpu_commit_i,
  input  logic              cpu_kill_i,
  input  logic              underflow_clr_i,
  input  logic              host_in_i,
  input  logic              host_rd_i,
  input  logic              host_done_i,
  output logic              tx_ready_o,
  output logic              wr_allowed_o,
  output logic              kill_busy_o,
  output logic [CNT_W-1:0]  cpu_cnt_o,
  output logic [BUSY_W-1:0] busy_cnt_o,
  output logic              host_avail_o,
  output logic [DATA_W-1:0] host_data_o,
  output logic [CNT_W-1:0]  host_len_o,
  output logic              host_nak_o,
  output logic              underflow_o
);
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              commit_fire, done_fire, kill_fire, head_lost, wr_fire;
  logic [BANK_W-1:0] head, wr_bank;
  logic [BUSY_W-1:0] busy;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [CNT_W-1:0]  cnt, rd_len;

  inep_bank_ctrl #(.NUM_BANKS(NUM_BANKS), .BUSY_W(BUSY_W), .BANK_W(BANK_W)) i_ctrl (
    .clk_i, .rst_ni,
    .commit_i      (cpu_commit_i),
    .kill_i        (cpu_kill_i),
    .done_i        (host_done_i),
    .tx_ready_o    (tx_ready_o),
    .commit_fire_o (commit_fire),
    .done_fire_o   (done_fire),
    .kill_fire_o   (kill_fire),
    .kill_pend_o   (kill_busy_o),
    .head_lost_o   (head_lost),
    .head_o        (head),
    .wr_bank_o     (wr_bank),
    .busy_o        (busy)
  );

  inep_cpu_port #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) i_cpu (
    .clk_i, .rst_ni,
    .wr_i          (cpu_wr_i),
    .tx_ready_i    (tx_ready_o),
    .commit_fire_i (commit_fire),
    .kill_fire_i   (kill_fire),
    .wr_allowed_o  (wr_allowed_o),
    .wr_fire_o     (wr_fire),
    .wr_addr_o     (wr_addr),
    .cnt_o         (cnt)
  );

  inep_bank_store #(
    .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .PTR_W(PTR_W), .BANK_W(BANK_W)
  ) i_store (
    .clk_i, .rst_ni,
    .wr_fire_i     (wr_fire),
    .wr_bank_i     (wr_bank),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (cpu_data_i),
    .commit_fire_i (commit_fire),
    .commit_len_i  (cnt),
    .rd_bank_i     (head),
    .rd_addr_i     (rd_addr),
    .rd_data_o     (host_data_o),
    .rd_len_o      (rd_len)
  );

  inep_host_port #(.CNT_W(CNT_W), .PTR_W(PTR_W), .BUSY_W(BUSY_W)) i_host (
    .clk_i, .rst_ni,
    .host_in_i   (host_in_i),
    .host_rd_i   (host_rd_i),
    .uf_clr_i    (underflow_clr_i),
    .busy_i      (busy),
    .head_len_i  (rd_len),
    .head_lost_i (head_lost),
    .rd_addr_o   (rd_addr),
    .nak_o       (host_nak_o),
    .underflow_o (underflow_o)
  );

  logic unused_done;
  assign unused_done  = done_fire;
  assign cpu_cnt_o    = cnt;
  assign busy_cnt_o   = busy;
  assign host_avail_o = (busy != '0);
  assign host_len_o   = (busy == '0) ? '0 : rd_len;
endmodule

// File: rtl/inep_buf_mgr_chk.sv
module inep_buf_mgr_chk #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned DEPTH     = 8,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1),
  localparam int unsigned BUSY_W   = $clog2(NUM_BANKS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_commit_i,
  input logic              host_in_i,
  input logic              host_done_i,
  input logic              tx_ready_o,
  input logic              wr_allowed_o,
  input logic              kill_busy_o,
  input logic [BUSY_W-1:0] busy_cnt_o,
  input logic [CNT_W-1:0]  host_len_o,
  input logic              host_nak_o,
  input logic              underflow_o
);
  p_busy_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(busy_cnt_o) <= int'(NUM_BANKS));

  p_kill_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_busy_o |=> !kill_busy_o);

  p_kill_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_busy_o |-> (!tx_ready_o && !wr_allowed_o));

  p_commit_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_commit_i && tx_ready_o && !host_done_i) |=> busy_cnt_o == $past(busy_cnt_o) + BUSY_W'(1));

  p_done_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_done_i && busy_cnt_o != '0 && !kill_busy_o && !(cpu_commit_i && tx_ready_o))
      |=> busy_cnt_o == $past(busy_cnt_o) - BUSY_W'(1));

  p_full_not_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(busy_cnt_o) == int'(NUM_BANKS)) |-> !tx_ready_o);

  p_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_in_i && busy_cnt_o == '0) |=> (underflow_o && host_nak_o));

  p_idle_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_cnt_o == '0) |-> (host_len_o == '0));
endmodule

bind inep_buf_mgr inep_buf_mgr_chk #(.NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)) i_inep_buf_mgr_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_commit_i (cpu_commit_i),
  .host_in_i    (host_in_i),
  .host_done_i  (host_done_i),
  .tx_ready_o   (tx_ready_o),
  .wr_allowed_o (wr_allowed_o),
  .kill_busy_o  (kill_busy_o),
  .busy_cnt_o   (busy_cnt_o),
  .host_len_o   (host_len_o),
  .host_nak_o   (host_nak_o),
  .underflow_o  (underflow_o)
);

// File: tb/test_inep_buf_mgr.sv
module test_inep_buf_mgr;
  localparam int DP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       cpu_wr = 0, cpu_commit = 0, cpu_kill = 0, uf_clr = 0;
  logic       host_in = 0, host_rd = 0, host_done = 0;
  logic [7:0] cpu_data = '0;
  logic       tx_ready, wr_allowed, kill_busy, host_avail, host_nak, underflow;
  logic [3:0] cpu_cnt, host_len;
  logic [1:0] busy;
  logic [7:0] host_data;

  logic       s_wr = 0, s_commit = 0, s_done = 0;
  logic [7:0] s_data = '0;
  logic       s_tx_ready, s_wr_allowed, s_kill_busy, s_avail, s_nak, s_uf;
  logic [3:0] s_cnt, s_len;
  logic [0:0] s_busy;
  logic [7:0] s_hdata;

  int n_chk = 0;
  int n_fail = 0;

  inep_buf_mgr #(.NUM_BANKS(2), .DEPTH(DP), .DATA_W(8)) i_inep_buf_mgr (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_wr_i(cpu_wr), .cpu_data_i(cpu_data), .cpu_commit_i(cpu_commit), .cpu_kill_i(cpu_kill),
    .underflow_clr_i(uf_clr), .host_in_i(host_in), .host_rd_i(host_rd), .host_done_i(host_done),
    .tx_ready_o(tx_ready), .wr_allowed_o(wr_allowed), .kill_busy_o(kill_busy), .cpu_cnt_o(cpu_cnt),
    .busy_cnt_o(busy), .host_avail_o(host_avail), .host_data_o(host_data), .host_len_o(host_len),
    .host_nak_o(host_nak), .underflow_o(underflow)
  );

  inep_buf_mgr #(.NUM_BANKS(1), .DEPTH(DP), .DATA_W(8)) i_inep_buf_mgr_one (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_wr_i(s_wr), .cpu_data_i(s_data), .cpu_commit_i(s_commit), .cpu_kill_i(1'b0),
    .underflow_clr_i(1'b0), .host_in_i(1'b0), .host_rd_i(1'b0), .host_done_i(s_done),
    .tx_ready_o(s_tx_ready), .wr_allowed_o(s_wr_allowed), .kill_busy_o(s_kill_busy), .cpu_cnt_o(s_cnt),
    .busy_cnt_o(s_busy), .host_avail_o(s_avail), .host_data_o(s_hdata), .host_len_o(s_len),
    .host_nak_o(s_nak), .underflow_o(s_uf)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int s, int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic step();
    @(negedge clk);
    cpu_wr = 0; cpu_commit = 0; cpu_kill = 0; uf_clr = 0;
    host_in = 0; host_rd = 0; host_done = 0;
    s_wr = 0; s_commit = 0; s_done = 0;
  endtask

  task automatic wr_bytes(int s, int n);
    for (int i = 0; i < n; i++) begin
      cpu_wr = 1; cpu_data = pat(s, i); step();
    end
  endtask

  task automatic commit();
    cpu_commit = 1; step();
  endtask

  task automatic release_bank();
    host_done = 1; step();
  endtask

  task automatic read_check(string req, int s, int n);
    for (int i = 0; i < n; i++) begin
      check(req, int'(host_data), int'(pat(s, i)));
      host_rd = 1; step();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 tx_ready", int'(tx_ready), 1);
    check("R1 wr_allowed", int'(wr_allowed), 1);
    check("R1 cpu_cnt", int'(cpu_cnt), 0);
    check("R1 kill_busy", int'(kill_busy), 0);
    check("R1 underflow", int'(underflow), 0);
    check("R1 nak", int'(host_nak), 0);
    check("R1 host_len", int'(host_len), 0);

    // sweep every split of one bank pair
    for (int l = 0; l <= DP; l++) begin
      int m;
      m = DP - l;
      wr_bytes(2 * l, l);
      check("R2 cnt", int'(cpu_cnt), l);
      check("R2 wr_allowed", int'(wr_allowed), (l < DP) ? 1 : 0);
      if (l == DP) begin
        cpu_wr = 1; cpu_data = 8'hEE; step();
        check("R2 full write ignored", int'(cpu_cnt), DP);
      end
      commit();
      check("R3 busy after commit", int'(busy), 1);
      check("R3 ready again", int'(tx_ready), 1);
      check("R3 cnt cleared", int'(cpu_cnt), 0);
      check("R4 host_len", int'(host_len), l);
      for (int i = 0; i < DP; i++) begin
        if (i < l) begin
          check("R6 host byte during fill", int'(host_data), int'(pat(2 * l, i)));
          host_rd = 1;
        end
        if (i < m) begin
          cpu_wr = 1; cpu_data = pat(2 * l + 1, i);
        end
        step();
      end
      check("R6 fill count", int'(cpu_cnt), m);
      commit();
      check("R3 busy two", int'(busy), 2);
      check("R3 not ready full", int'(tx_ready), 0);
      cpu_commit = 1; step();
      check("R3 commit ignored", int'(busy), 2);
      release_bank();
      check("R5 busy after release", int'(busy), 1);
      check("R5 ready after release", int'(tx_ready), 1);
      check("R4 second len", int'(host_len), m);
      read_check("R4 second bank data", 2 * l + 1, m);
      release_bank();
      check("R5 busy empty", int'(busy), 0);
      check("R9 idle len", int'(host_len), 0);
    end

    // R7 kill of the newest bank
    wr_bytes(100, 3); commit();
    wr_bytes(101, 2); commit();
    check("R7 setup busy", int'(busy), 2);
    cpu_kill = 1; step();
    check("R7 kill pending", int'(kill_busy), 1);
    check("R8 ready low", int'(tx_ready), 0);
    check("R8 wr_allowed low", int'(wr_allowed), 0);
    step();
    check("R7 kill cleared", int'(kill_busy), 0);
    check("R7 busy after kill", int'(busy), 1);
    check("R7 older len kept", int'(host_len), 3);
    wr_bytes(102, 4); commit();
    check("R7 refill busy", int'(busy), 2);
    read_check("R7 older data kept", 100, 3);
    release_bank();
    check("R7 killed bank skipped len", int'(host_len), 4);
    check("R7 killed bank skipped data", int'(host_data), int'(pat(102, 0)));
    wr_bytes(103, 2);
    check("R7 partial cnt", int'(cpu_cnt), 2);
    cpu_kill = 1; step();
    cpu_wr = 1; cpu_data = 8'h55; step();
    check("R7 busy zero", int'(busy), 0);
    check("R7 cnt cleared", int'(cpu_cnt), 0);
    check("R7 host_len zero", int'(host_len), 0);
    cpu_kill = 1; step();
    check("R7 kill pend on empty", int'(kill_busy), 1);
    cpu_wr = 1; cpu_data = 8'h66; cpu_commit = 1; step();
    check("R8 write ignored", int'(cpu_cnt), 0);
    check("R8 commit ignored", int'(busy), 0);
    check("R7 empty kill clears", int'(kill_busy), 0);

    // R12 kill and release together
    wr_bytes(104, 1); commit();
    wr_bytes(105, 1); commit();
    cpu_kill = 1; step();
    host_done = 1; step();
    check("R12 both freed", int'(busy), 0);
    check("R12 ready", int'(tx_ready), 1);

    // R9 underflow
    host_in = 1; step();
    check("R9 underflow set", int'(underflow), 1);
    check("R9 nak pulse", int'(host_nak), 1);
    check("R9 busy unchanged", int'(busy), 0);
    step();
    check("R9 nak one cycle", int'(host_nak), 0);
    check("R9 sticky", int'(underflow), 1);
    uf_clr = 1; step();
    check("R9 cleared", int'(underflow), 0);
    wr_bytes(106, 1); commit();
    host_in = 1; step();
    check("R9 no nak when busy", int'(host_nak), 0);
    check("R9 no underflow when busy", int'(underflow), 0);
    release_bank();

    // R10 single bank
    check("R10 ready idle", int'(s_tx_ready), 1);
    s_wr = 1; s_data = pat(200, 0); step();
    s_wr = 1; s_data = pat(200, 1); step();
    s_commit = 1; step();
    check("R10 not ready after commit", int'(s_tx_ready), 0);
    check("R10 busy", int'(s_busy), 1);
    check("R10 wr blocked", int'(s_wr_allowed), 0);
    s_wr = 1; s_data = 8'h77; step();
    check("R10 write ignored", int'(s_cnt), 0);
    check("R10 data", int'(s_hdata), int'(pat(200, 0)));
    check("R10 len", int'(s_len), 2);
    s_done = 1; step();
    check("R10 ready after release", int'(s_tx_ready), 1);
    check("R10 busy empty", int'(s_busy), 0);

    summary();
  end
endmodule